// File: doc/BRIEF.md
# Horizontal Sync Separator with Half-Line Rejection

This block takes a composite sync signal that has already been sliced to a logic level and sampled on the pixel clock of an LCD timing generator. From it the block produces a clean, one-cycle line-reset strobe that marks the start of each line for the rest of the timing logic. A horizontal counter free-runs at the line period set by the panel mode: 638 clocks for the narrow panel and 702 for the wide one. Sync edges only correct the phase of this counter, so the strobe keeps coming when the input is noisy, broken or missing.

An edge counts as a sync edge only after the input has stayed high for a minimum number of clocks. While the block is locked, it ignores accepted edges that land in the middle half of the line. Those are equalizing and serration pulses at the half-line rate. A small phase error is corrected at once. A large one sets a jump flag, and the counter moves to the new phase only if the jump repeats on consecutive lines. This keeps the count of lines per field stable when a single line is disturbed. The sync-present flag falls after a number of silent lines that depends on the TV standard.

Top module: `hsync_separator`

## Requirements
- R1: With no accepted sync edge, `line_rst_o` is high for one cycle every P clocks, where P = 638 when `panel_wide_i`=0 and P = 702 when `panel_wide_i`=1.
- R2: `sync_i` is active high. A pulse is accepted only when `sync_i` is sampled high on at least 8 consecutive clock edges. A 7-clock pulse has no effect, and each pulse is accepted at most once.
- R3: The outputs respond to an accepted pulse on the tenth rising edge, counting the first edge that samples `sync_i` high as edge one.
- R4: Let h be the number of clocks since the last `line_rst_o` cycle, taken in the cycle just before the response edge. While `sync_ok_o`=1, an accepted pulse with floor(P/4) <= h < floor(3P/4) is ignored: no strobe, no jump flag, no change of line phase and no change to the jump count.
- R5: Let d be the circular distance of (h+1) mod P from 0. While locked, an accepted pulse with d <= 8 restarts the line (`line_rst_o` high in the response cycle), keeps `jump_o` low and clears the consecutive-jump count.
- R6: While locked, an accepted pulse with d > 8 that lies outside the R4 window raises `jump_o` for the single response cycle. The first and second consecutive jumps leave the line phase unchanged.
- R7: The third consecutive jump restarts the line at the new position, with `line_rst_o` high in its response cycle.
- R8: While `sync_ok_o`=0, any accepted pulse restarts the line and sets `sync_ok_o`, with the R4 window not applied and `jump_o` kept low.
- R9: `sync_ok_o` falls in the same cycle as the 4th `line_rst_o` strobe (when `std_pal_i`=0) or the 5th strobe (when `std_pal_i`=1) after the line restart made by the last good edge, if no good edge arrives in between.
- R10: During reset `line_rst_o`, `jump_o` and `sync_ok_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Sliced composite sync, high during the sync tip |
| panel_wide_i | input | 1 | Panel mode: 0 gives a 638-clock line, 1 gives a 702-clock line |
| std_pal_i | input | 1 | TV standard: 0 gives a 4-line loss timeout, 1 gives a 5-line timeout |
| line_rst_o | output | 1 | One-cycle strobe at each line start |
| sync_ok_o | output | 1 | Sync-present flag |
| jump_o | output | 1 | One-cycle flag for a sync edge far from the expected phase |

## Verification
The bound checker checks on every cycle the relations between internal events and the ports. A pulse is accepted at most once, and only after the input was high. A killed edge never restarts the line. Every phase load yields a strobe on the next cycle. A jump flag always follows an accept made while locked. Acquisition sets the flag and restarts the line. The flag falls only on a silent line wrap. The bench scenarios cover what needs history or exact positions: the 7- and 8-clock filter boundary, the exact response latency, both edges of the kill window, the tolerance limit of 8, the counted third-jump realignment, the 4- and 5-line loss timeouts and the wide-panel period.

// File: rtl/hsep_pkg.sv
package hsep_pkg;

  // True when a counter position falls inside the half-line rejection zone.
  function automatic logic in_half_zone(input int unsigned pos, input int unsigned period);
    return (pos >= period / 4) && (pos < (3 * period) / 4);
  endfunction

  // Circular distance, in clocks, between the next counter position and line start.
  function automatic int unsigned wrap_dist(input int unsigned pos, input int unsigned period);
    int unsigned ph;
    ph = (pos + 1 >= period) ? 0 : pos + 1;
    return (ph <= period / 2) ? ph : period - ph;
  endfunction

endpackage

// File: rtl/hsep_glitch_filter.sv
module hsep_glitch_filter #(
  parameter int unsigned MIN_WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic accept_o
);
  localparam int unsigned RW = $clog2(MIN_WIDTH + 1);

  logic [1:0]    sync_sr;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_sr <= '0;
      run     <= '0;
    end else begin
      sync_sr <= {sync_sr[0], sync_i};
      if (!sync_sr[1])
        run <= '0;
      else if (run != RW'(MIN_WIDTH))
        run <= run + 1'b1;
    end
  end

  // One strobe on the MIN_WIDTH-th consecutive high sample; run then saturates.
  assign accept_o = sync_sr[1] && (run == RW'(MIN_WIDTH - 1));
endmodule

// File: rtl/hsep_line_counter.sv
module hsep_line_counter #(
  parameter int unsigned LINE_NARROW = 638,
  parameter int unsigned LINE_WIDE   = 702,
  parameter int unsigned CW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_i,
  input  logic          load_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] LAST_N = CW'(LINE_NARROW - 1);
  localparam logic [CW-1:0] LAST_W = CW'(LINE_WIDE - 1);

  logic [CW-1:0] last;

  assign last   = wide_i ? LAST_W : LAST_N;
  assign wrap_o = (cnt_o >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_o <= CW'(1);
    else if (load_i || wrap_o)
      cnt_o <= '0;
    else
      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/hsep_lock_ctrl.sv
module hsep_lock_ctrl
  import hsep_pkg::*;
#(
  parameter int unsigned LINE_NARROW     = 638,
  parameter int unsigned LINE_WIDE       = 702,
  parameter int unsigned CW              = 10,
  parameter int unsigned NEAR_TOL        = 8,
  parameter int unsigned JUMP_LIMIT      = 3,
  parameter int unsigned LOSS_LINES_NTSC = 4,
  parameter int unsigned LOSS_LINES_PAL  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          wrap_i,
  input  logic          wide_i,
  input  logic          pal_i,
  output logic          load_o,
  output logic          half_kill_o,
  output logic          sync_ok_o,
  output logic          jump_o
);
  localparam int unsigned JW       = $clog2(JUMP_LIMIT + 1);
  localparam int unsigned LOSS_MAX = (LOSS_LINES_PAL > LOSS_LINES_NTSC) ? LOSS_LINES_PAL : LOSS_LINES_NTSC;
  localparam int unsigned MW       = $clog2(LOSS_MAX + 1);

  logic [JW-1:0] jcnt;
  logic [MW-1:0] miss;
  logic [MW-1:0] miss_last;
  int unsigned   period;
  logic          half, near, acquire, good, jump_ev, realign;

  always_comb begin
    period   = wide_i ? LINE_WIDE : LINE_NARROW;
    half     = sync_ok_o && in_half_zone(32'(cnt_i), period);
    near     = wrap_dist(32'(cnt_i), period) <= NEAR_TOL;
    acquire  = accept_i && !sync_ok_o;
    good     = accept_i && sync_ok_o && near;
    jump_ev  = accept_i && sync_ok_o && !near && !half;
    realign  = jump_ev && (jcnt == JW'(JUMP_LIMIT - 1));
    miss_last = pal_i ? MW'(LOSS_LINES_PAL - 1) : MW'(LOSS_LINES_NTSC - 1);
  end

  assign load_o      = acquire || good || realign;
  assign half_kill_o = accept_i && half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jcnt      <= '0;
      miss      <= '0;
      sync_ok_o <= 1'b0;
      jump_o    <= 1'b0;
    end else begin
      jump_o <= jump_ev;
      if (load_o)
        jcnt <= '0;
      else if (jump_ev)
        jcnt <= jcnt + 1'b1;

      if (load_o) begin
        miss      <= '0;
        sync_ok_o <= 1'b1;
      end else if (sync_ok_o && wrap_i) begin
        if (miss == miss_last) begin
          miss      <= '0;
          sync_ok_o <= 1'b0;
        end else begin
          miss <= miss + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hsync_separator.sv
module hsync_separator #(
  parameter int unsigned LINE_NARROW     = 638,
  parameter int unsigned LINE_WIDE       = 702,
  parameter int unsigned MIN_WIDTH       = 8,
  parameter int unsigned NEAR_TOL        = 8,
  parameter int unsigned JUMP_LIMIT      = 3,
  parameter int unsigned LOSS_LINES_NTSC = 4,
  parameter int unsigned LOSS_LINES_PAL  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic panel_wide_i,
  input  logic std_pal_i,
  output logic line_rst_o,
  output logic sync_ok_o,
  output logic jump_o
);
  localparam int unsigned LINE_MAX = (LINE_WIDE > LINE_NARROW) ? LINE_WIDE : LINE_NARROW;
  localparam int unsigned CW       = $clog2(LINE_MAX);

  logic          accept_w;
  logic          load_w;
  logic          wrap_w;
  logic          half_kill_w;
  logic [CW-1:0] cnt_w;

  hsep_glitch_filter #(.MIN_WIDTH(MIN_WIDTH)) u_filter (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .accept_o(accept_w)
  );

  hsep_line_counter #(.LINE_NARROW(LINE_NARROW), .LINE_WIDE(LINE_WIDE), .CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .wide_i(panel_wide_i), .load_i(load_w),
    .cnt_o(cnt_w), .wrap_o(wrap_w)
  );

  hsep_lock_ctrl #(
    .LINE_NARROW(LINE_NARROW), .LINE_WIDE(LINE_WIDE), .CW(CW), .NEAR_TOL(NEAR_TOL),
    .JUMP_LIMIT(JUMP_LIMIT), .LOSS_LINES_NTSC(LOSS_LINES_NTSC), .LOSS_LINES_PAL(LOSS_LINES_PAL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .cnt_i(cnt_w), .wrap_i(wrap_w),
    .wide_i(panel_wide_i), .pal_i(std_pal_i), .load_o(load_w), .half_kill_o(half_kill_w),
    .sync_ok_o(sync_ok_o), .jump_o(jump_o)
  );

  assign line_rst_o = (cnt_w == '0);
endmodule

// File: rtl/hsep_checker.sv
module hsep_checker #(
  parameter int unsigned LINE_MAX = 702,
  parameter int unsigned CW       = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_i,
  input logic          accept,
  input logic          half_kill,
  input logic          load,
  input logic          wrap,
  input logic [CW-1:0] cnt,
  input logic          line_rst_o,
  input logic          sync_ok_o,
  input logic          jump_o
);
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LINE_MAX));

  p_single_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  p_accept_needs_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(sync_i, 2));

  p_kill_keeps_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_kill && !wrap) |=> !line_rst_o);

  p_load_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> line_rst_o);

  p_jump_from_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |-> ($past(accept) && $past(sync_ok_o)));

  p_acquire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sync_ok_o) |=> (sync_ok_o && line_rst_o && !jump_o));

  p_loss_on_quiet_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_ok_o) |-> ($past(wrap) && !$past(accept)));
endmodule

bind hsync_separator hsep_checker #(.LINE_MAX(LINE_MAX), .CW(CW)) u_hsep_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .accept(accept_w), .half_kill(half_kill_w),
  .load(load_w), .wrap(wrap_w), .cnt(cnt_w), .line_rst_o(line_rst_o),
  .sync_ok_o(sync_ok_o), .jump_o(jump_o)
);

// File: tb/test_hsync_separator.sv
`timescale 1ns/1ps
module test_hsync_separator;
  localparam int PN = 638;
  localparam int PW = 702;

  logic clk = 1'b0, rst_n = 1'b0, sync_i = 1'b0, wide = 1'b0, pal = 1'b0;
  logic line_rst, sync_ok, jump;
  int cyc = 0, checks = 0, errors = 0, T = 0, P = PN;
  bit done = 0;

  typedef struct { int at; int sig; logic val; string req; } exp_t;
  exp_t sb[$];
  exp_t e;

  hsync_separator i_hsync_separator (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .panel_wide_i(wide), .std_pal_i(pal),
    .line_rst_o(line_rst), .sync_ok_o(sync_ok), .jump_o(jump)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  // Driver side: queue an expected output value for a given cycle, kept sorted.
  task automatic push(int at, int sig, logic val, string req);
    exp_t x;
    int idx;
    x.at = at; x.sig = sig; x.val = val; x.req = req;
    idx = sb.size();
    for (int i = 0; i < sb.size(); i++) if (sb[i].at > at) begin idx = i; break; end
    sb.insert(idx, x);
  endtask

  // Monitor side: compare outputs in the cycle each item names.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      if (e.at < cyc) begin
        checks++; errors++;
        $display("FAIL %s: item for cycle %0d missed, actual n/a expected %0b", e.req, e.at, e.val);
      end else begin
        case (e.sig)
          0:       chk(e.req, line_rst, e.val);
          1:       chk(e.req, jump, e.val);
          default: chk(e.req, sync_ok, e.val);
        endcase
      end
    end
  end

  task automatic wait_rst();
    @(negedge clk);
    while (!line_rst) @(negedge clk);
    T = cyc;
  endtask

  // Start cycle of a pulse whose accept sees position h since the last strobe T.
  function automatic int next_c(int h);
    int c;
    c = T + h - 9;
    while (c <= cyc) c += P;
    return c;
  endfunction

  task automatic pulse(int c, int w);
    while (cyc < c) @(negedge clk);
    sync_i = 1'b1;
    repeat (w) @(negedge clk);
    sync_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    finish_run();
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk("R10 line_rst_o in reset", line_rst, 1'b0);
    chk("R10 jump_o in reset", jump, 1'b0);
    chk("R10 sync_ok_o in reset", sync_ok, 1'b0);
    rst_n = 1'b1;

    // R1 free run, narrow panel
    wait_rst();
    push(T + P - 1, 0, 1'b0, "R1 no early strobe");
    push(T + P, 0, 1'b1, "R1 strobe after P clocks");
    push(T + P, 2, 1'b0, "R8 flag low while unlocked");
    wait_rst();

    // R8 acquire at mid-line while unlocked; R3 latency
    c = next_c(300);
    push(c + 9, 2, 1'b0, "R3 no response before edge ten");
    push(c + 10, 2, 1'b1, "R8 flag set on acquire");
    push(c + 10, 0, 1'b1, "R3 R8 strobe on acquire");
    push(c + 10, 1, 1'b0, "R8 no jump on acquire");
    pulse(c, 40); T = c + 10;

    // R5 aligned edge
    c = next_c(P - 1);
    push(c + 10, 0, 1'b1, "R5 aligned strobe");
    push(c + 10, 1, 1'b0, "R5 aligned no jump");
    pulse(c, 40); T = c + 10;

    // R2 7-clock noise at a position that would otherwise jump
    c = next_c(P - 21);
    push(c + 10, 0, 1'b0, "R2 short pulse no strobe");
    push(c + 10, 1, 1'b0, "R2 short pulse no jump");
    pulse(c, 7);

    // R2 8-clock pulse accepted, early by 5 (R5)
    c = next_c(P - 6);
    push(c + 9, 0, 1'b0, "R5 no strobe before early edge");
    push(c + 10, 0, 1'b1, "R2 R5 8-clock pulse restarts line");
    push(c + 10, 1, 1'b0, "R5 early by 5 no jump");
    pulse(c, 8); T = c + 10;

    // R5 late by 8, tolerance limit
    c = next_c(7);
    push(c + 10, 0, 1'b1, "R5 late by 8 restarts");
    push(c + 10, 1, 1'b0, "R5 late by 8 no jump");
    pulse(c, 40); T = c + 10;

    // R4 kill window lower and upper inside edges
    c = next_c(159);
    push(c + 10, 0, 1'b0, "R4 kill at P/4 no strobe");
    push(c + 10, 1, 1'b0, "R4 kill at P/4 no jump");
    push(T + ((c + 10 - T) / P + 1) * P, 0, 1'b1, "R4 phase kept after kill");
    pulse(c, 40);
    c = next_c(477);
    push(c + 10, 0, 1'b0, "R4 kill at 3P/4-1 no strobe");
    push(c + 10, 1, 1'b0, "R4 kill at 3P/4-1 no jump");
    pulse(c, 40);

    // R6 just outside the window
    c = next_c(158);
    push(c + 10, 1, 1'b1, "R6 jump below window");
    push(c + 10, 0, 1'b0, "R6 first jump keeps phase");
    pulse(c, 40);
    c = next_c(P - 1);
    push(c + 10, 1, 1'b0, "R5 aligned after jump");
    push(c + 10, 0, 1'b1, "R5 aligned strobe after jump");
    pulse(c, 40); T = c + 10;
    c = next_c(478);
    push(c + 10, 1, 1'b1, "R4 R6 jump at 3P/4");
    pulse(c, 40);
    c = next_c(P - 1);
    push(c + 10, 0, 1'b1, "R5 count cleared by aligned edge");
    pulse(c, 40); T = c + 10;

    // R7 three consecutive jumps
    for (int i = 0; i < 3; i++) begin
      c = next_c(100);
      push(c + 10, 1, 1'b1, "R6 R7 jump flagged");
      push(c + 10, 0, (i == 2) ? 1'b1 : 1'b0, "R7 realign only on third jump");
      pulse(c, 40);
      if (i == 2) T = c + 10;
    end
    c = next_c(P - 1);
    push(c + 10, 1, 1'b0, "R7 new phase holds");
    push(c + 10, 0, 1'b1, "R7 new phase strobe");
    pulse(c, 40); T = c + 10;

    // R9 loss, NTSC timeout
    push(T + 4 * P - 1, 2, 1'b1, "R9 flag held before 4th strobe");
    push(T + 4 * P, 2, 1'b0, "R9 flag falls on 4th strobe");
    while (cyc <= T + 4 * P) @(negedge clk);

    // R9 loss, PAL timeout
    pal = 1'b1;
    c = next_c(200);
    push(c + 10, 2, 1'b1, "R8 reacquire");
    pulse(c, 40); T = c + 10;
    push(T + 5 * P - 1, 2, 1'b1, "R9 PAL flag held before 5th strobe");
    push(T + 5 * P, 2, 1'b0, "R9 PAL flag falls on 5th strobe");
    while (cyc <= T + 5 * P) @(negedge clk);

    // R1 wide panel period
    wide = 1'b1; P = PW;
    wait_rst();
    push(T + PW - 1, 0, 1'b0, "R1 wide no early strobe");
    push(T + PW, 0, 1'b1, "R1 wide strobe after 702");
    while (sb.size() > 0) @(negedge clk);
    finish_run();
  end
endmodule